// File: doc/BRIEF.md
# Dual-Mode Video Slot Timing Generator

This block produces the horizontal and vertical timing for a tile-based video display processor. Each input clock cycle is one master clock. The master clock is divided into access slots, and a horizontal slot counter steps through 256 slots per line. There are two width modes. The wide mode uses 16-clock slots, except during horizontal sync, where each slot's length comes from a fixed 17-entry schedule. The narrow mode uses 20-clock slots throughout.

A vertical line counter advances on a single-cycle line-change strobe that fires at one fixed slot of every line. The block decodes horizontal sync and horizontal blank from the slot counter. It also issues a strobe at the slot where the vertical interrupt is raised on the first inactive line. Both the width mode and the 50/60 Hz standard are sampled once per frame, at line 0 slot 0. The sampled standard sets the first inactive line and the frame length. A frame counter steps when the line counter reaches eight lines past the first inactive line.

Top module: `vid_slot_timing`

## Requirements
- R1: A synchronous reset drives the slot counter, line counter, frame counter and both sampled mode bits to zero. hsync, line_chg and vint_strobe are then low, and hblank is low because slot 0 is outside blank.
- R2: Ordinary slots last 16 master clocks when mode_wide is 1 and 20 master clocks when mode_wide is 0. The slot counter increments by one per slot and wraps from 255 to 0.
- R3: In wide mode, slots 234 through 250 take their lengths from this schedule. Entries 0 and 16 last 19 clocks, entries 4, 8 and 12 last 18 clocks, and all others last 20 clocks. One wide-mode sync period therefore lasts 332 master clocks.
- R4: In wide mode, hsync is high exactly while the slot counter is in 234..250, which is 17 slots.
- R5: In narrow mode, hsync is high exactly while the slot counter is in 210..242. That is 33 slots, or 660 master clocks.
- R6: hblank is high from slot 178 through slot 255 in wide mode, and from slot 233 through slot 255 in narrow mode. It is low at slot 0.
- R7: vint_strobe is high for exactly the first master clock of slot 4 (wide) or slot 23 (narrow), and only on the first inactive line.
- R8: line_chg is high for exactly the first master clock of slot 165 (wide) or slot 133 (narrow). The line counter changes only in the cycle after line_chg.
- R9: With mode_pal 0, the first inactive line is NTSC_ACTIVE and the counter wraps from NTSC_LINES-1 to 0. With mode_pal 1, these values are PAL_ACTIVE and PAL_LINES. Defaults are 224/262 and 240/313.
- R10: wide_in and pal_in are copied to mode_wide and mode_pal only in the first master clock of slot 0 on line 0. Changes to them at any other time have no effect on any output until that point.
- R11: frame_cnt increments by one when the line counter steps to the first inactive line plus 8, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_in | input | 1 | Requested width mode (1 = wide) |
| pal_in | input | 1 | Requested standard (1 = 50 Hz) |
| hslot | output | SLOT_W | Horizontal slot counter |
| vline | output | LINE_W | Vertical line counter |
| frame_cnt | output | FRAME_W | Frame counter |
| hsync | output | 1 | Horizontal sync active |
| hblank | output | 1 | Horizontal blank active |
| line_chg | output | 1 | Single-cycle line-change strobe |
| vint_strobe | output | 1 | Single-cycle vertical interrupt slot marker |
| mode_wide | output | 1 | Width mode sampled for this frame |
| mode_pal | output | 1 | Standard sampled for this frame |

## Verification
The assertions rely only on reset being held for at least one clock before counting starts. They place no limit on how wide_in and pal_in may toggle, since both mode bits are sampled internally. The stimulus changes these two inputs at random cycles, so they often differ from the sampled mode mid-frame and take random values at frame boundaries. Line counts are reduced so that several frames in both standards fit within the run. This exercises mode changes, line wraps and frame steps.

// File: rtl/vid_slot_timing_pkg.sv
package vid_slot_timing_pkg;

   localparam int unsigned WIDE_SYNC_SLOTS = 17;

   // Sampled display mode for one frame
   typedef struct packed {
      logic wide;
      logic pal;
   } vmode_t;

   // Master-clock length of entry idx of the wide-mode sync schedule
   function automatic logic [4:0] wide_sync_len(input logic [7:0] idx);
      if (idx == 8'd0 || idx == 8'd16) return 5'd19;
      else if (idx[1:0] == 2'b00)      return 5'd18;
      else                             return 5'd20;
   endfunction

endpackage

// File: rtl/vst_slot_div.sv
module vst_slot_div
   import vid_slot_timing_pkg::*;
#(
   parameter int SLOT_W        = 8,
   parameter int PH_W          = 5,
   parameter int MCLK_WIDE     = 16,
   parameter int MCLK_NARROW   = 20,
   parameter int WIDE_HS_START = 234
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wide,
   output logic [SLOT_W-1:0] hslot,
   output logic              slot_first
);

   localparam logic [SLOT_W-1:0] HS_LO = SLOT_W'(WIDE_HS_START);
   localparam logic [SLOT_W-1:0] HS_HI = SLOT_W'(WIDE_HS_START + WIDE_SYNC_SLOTS);

   logic [PH_W-1:0]   phase;
   logic [PH_W-1:0]   slot_len;
   logic [SLOT_W-1:0] sync_idx;
   logic              in_sync;

   always_comb begin
      sync_idx = hslot - HS_LO;
      in_sync  = (hslot >= HS_LO) && (hslot < HS_HI);
      if (!wide)        slot_len = PH_W'(MCLK_NARROW);
      else if (in_sync) slot_len = PH_W'(wide_sync_len(8'(sync_idx)));
      else              slot_len = PH_W'(MCLK_WIDE);
   end

   assign slot_first = (phase == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         hslot <= '0;
      end else if (phase == slot_len - PH_W'(1)) begin
         phase <= '0;
         hslot <= hslot + SLOT_W'(1);
      end else begin
         phase <= phase + PH_W'(1);
      end
   end

endmodule

// File: rtl/vst_line_ctr.sv
module vst_line_ctr
   import vid_slot_timing_pkg::*;
#(
   parameter int SLOT_W      = 8,
   parameter int LINE_W      = 9,
   parameter int FRAME_W     = 16,
   parameter int LC_WIDE     = 165,
   parameter int LC_NARROW   = 133,
   parameter int NTSC_LINES  = 262,
   parameter int NTSC_ACTIVE = 224,
   parameter int PAL_LINES   = 313,
   parameter int PAL_ACTIVE  = 240,
   parameter int FRAME_OFS   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               slot_first,
   input  logic [SLOT_W-1:0]  hslot,
   input  logic               wide_in,
   input  logic               pal_in,
   output vmode_t             mode,
   output logic [LINE_W-1:0]  vline,
   output logic [LINE_W-1:0]  first_inact,
   output logic [FRAME_W-1:0] frame_cnt,
   output logic               line_chg
);

   logic [SLOT_W-1:0] lc_slot;
   logic [LINE_W-1:0] last_line;
   logic [LINE_W-1:0] vline_nxt;
   logic              frame_start;

   always_comb begin
      lc_slot     = mode.wide ? SLOT_W'(LC_WIDE) : SLOT_W'(LC_NARROW);
      last_line   = mode.pal ? LINE_W'(PAL_LINES - 1) : LINE_W'(NTSC_LINES - 1);
      first_inact = mode.pal ? LINE_W'(PAL_ACTIVE) : LINE_W'(NTSC_ACTIVE);
      vline_nxt   = (vline == last_line) ? '0 : vline + LINE_W'(1);
      line_chg    = slot_first && (hslot == lc_slot);
      frame_start = slot_first && (hslot == '0) && (vline == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= '0;
      end else if (frame_start) begin
         mode.wide <= wide_in;
         mode.pal  <= pal_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vline     <= '0;
         frame_cnt <= '0;
      end else if (line_chg) begin
         vline <= vline_nxt;
         if (vline_nxt == first_inact + LINE_W'(FRAME_OFS))
            frame_cnt <= frame_cnt + FRAME_W'(1);
      end
   end

endmodule

// File: rtl/vst_hv_decode.sv
module vst_hv_decode #(
   parameter int SLOT_W        = 8,
   parameter int LINE_W        = 9,
   parameter int WIDE_HS_START = 234,
   parameter int WIDE_HS_SLOTS = 17,
   parameter int NAR_HS_START  = 210,
   parameter int NAR_HS_SLOTS  = 33,
   parameter int HB_WIDE       = 178,
   parameter int HB_NARROW     = 233,
   parameter int VINT_WIDE     = 4,
   parameter int VINT_NARROW   = 23
) (
   input  logic              wide,
   input  logic              slot_first,
   input  logic [SLOT_W-1:0] hslot,
   input  logic [LINE_W-1:0] vline,
   input  logic [LINE_W-1:0] first_inact,
   output logic              hsync,
   output logic              hblank,
   output logic              vint_strobe
);

   // Slot counters are compared at 32 bits so window ends above 255 are legal
   localparam int NUM_MODES = 2;
   localparam int HS_LO [NUM_MODES] = '{NAR_HS_START, WIDE_HS_START};
   localparam int HS_N  [NUM_MODES] = '{NAR_HS_SLOTS, WIDE_HS_SLOTS};
   localparam int HB_LO [NUM_MODES] = '{HB_NARROW, HB_WIDE};
   localparam int VI_AT [NUM_MODES] = '{VINT_NARROW, VINT_WIDE};

   logic [NUM_MODES-1:0] hs_m, hb_m, vi_m;

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      always_comb begin
         hs_m[m] = (32'(hslot) >= HS_LO[m]) && (32'(hslot) < HS_LO[m] + HS_N[m]);
         hb_m[m] = (32'(hslot) >= HB_LO[m]);
         vi_m[m] = (32'(hslot) == VI_AT[m]);
      end
   end

   assign hsync       = hs_m[wide];
   assign hblank      = hb_m[wide];
   assign vint_strobe = vi_m[wide] && slot_first && (vline == first_inact);

endmodule

// File: rtl/vid_slot_timing.sv
module vid_slot_timing
   import vid_slot_timing_pkg::*;
#(
   parameter int SLOT_W        = 8,
   parameter int LINE_W        = 9,
   parameter int FRAME_W       = 16,
   parameter int MCLK_WIDE     = 16,
   parameter int MCLK_NARROW   = 20,
   parameter int WIDE_HS_START = 234,
   parameter int NAR_HS_START  = 210,
   parameter int NAR_HS_SLOTS  = 33,
   parameter int HB_WIDE       = 178,
   parameter int HB_NARROW     = 233,
   parameter int VINT_WIDE     = 4,
   parameter int VINT_NARROW   = 23,
   parameter int LC_WIDE       = 165,
   parameter int LC_NARROW     = 133,
   parameter int NTSC_LINES    = 262,
   parameter int NTSC_ACTIVE   = 224,
   parameter int PAL_LINES     = 313,
   parameter int PAL_ACTIVE    = 240,
   parameter int FRAME_OFS     = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wide_in,
   input  logic               pal_in,
   output logic [SLOT_W-1:0]  hslot,
   output logic [LINE_W-1:0]  vline,
   output logic [FRAME_W-1:0] frame_cnt,
   output logic               hsync,
   output logic               hblank,
   output logic               line_chg,
   output logic               vint_strobe,
   output logic               mode_wide,
   output logic               mode_pal
);

   localparam int MAX_SLOT_LEN = (MCLK_NARROW > MCLK_WIDE) ?
                                 ((MCLK_NARROW > 20) ? MCLK_NARROW : 20) :
                                 ((MCLK_WIDE > 20) ? MCLK_WIDE : 20);
   localparam int PH_W       = $clog2(MAX_SLOT_LEN + 1);
   localparam int SLOTS_LINE = 1 << SLOT_W;

   // Elaboration-time parameter checks
   if (WIDE_HS_START + int'(WIDE_SYNC_SLOTS) > SLOTS_LINE)
      $error("wide sync window exceeds the line");
   if (NAR_HS_START + NAR_HS_SLOTS > SLOTS_LINE)
      $error("narrow sync window exceeds the line");
   if (NTSC_ACTIVE + FRAME_OFS >= NTSC_LINES || PAL_ACTIVE + FRAME_OFS >= PAL_LINES)
      $error("frame step line lies beyond the frame");
   if (PAL_LINES > (1 << LINE_W) || NTSC_LINES > (1 << LINE_W))
      $error("LINE_W too narrow for line count");
   if (MCLK_WIDE < 2 || MCLK_NARROW < 2)
      $error("slot length must be at least two clocks");

   vmode_t            mode;
   logic              slot_first;
   logic [LINE_W-1:0] first_inact;

   vst_slot_div #(
      .SLOT_W       (SLOT_W),
      .PH_W         (PH_W),
      .MCLK_WIDE    (MCLK_WIDE),
      .MCLK_NARROW  (MCLK_NARROW),
      .WIDE_HS_START(WIDE_HS_START)
   ) slot_div_i (
      .clk       (clk),
      .rst       (rst),
      .wide      (mode.wide),
      .hslot     (hslot),
      .slot_first(slot_first)
   );

   vst_line_ctr #(
      .SLOT_W     (SLOT_W),
      .LINE_W     (LINE_W),
      .FRAME_W    (FRAME_W),
      .LC_WIDE    (LC_WIDE),
      .LC_NARROW  (LC_NARROW),
      .NTSC_LINES (NTSC_LINES),
      .NTSC_ACTIVE(NTSC_ACTIVE),
      .PAL_LINES  (PAL_LINES),
      .PAL_ACTIVE (PAL_ACTIVE),
      .FRAME_OFS  (FRAME_OFS)
   ) line_ctr_i (
      .clk        (clk),
      .rst        (rst),
      .slot_first (slot_first),
      .hslot      (hslot),
      .wide_in    (wide_in),
      .pal_in     (pal_in),
      .mode       (mode),
      .vline      (vline),
      .first_inact(first_inact),
      .frame_cnt  (frame_cnt),
      .line_chg   (line_chg)
   );

   vst_hv_decode #(
      .SLOT_W       (SLOT_W),
      .LINE_W       (LINE_W),
      .WIDE_HS_START(WIDE_HS_START),
      .WIDE_HS_SLOTS(int'(WIDE_SYNC_SLOTS)),
      .NAR_HS_START (NAR_HS_START),
      .NAR_HS_SLOTS (NAR_HS_SLOTS),
      .HB_WIDE      (HB_WIDE),
      .HB_NARROW    (HB_NARROW),
      .VINT_WIDE    (VINT_WIDE),
      .VINT_NARROW  (VINT_NARROW)
   ) hv_decode_i (
      .wide       (mode.wide),
      .slot_first (slot_first),
      .hslot      (hslot),
      .vline      (vline),
      .first_inact(first_inact),
      .hsync      (hsync),
      .hblank     (hblank),
      .vint_strobe(vint_strobe)
   );

   assign mode_wide = mode.wide;
   assign mode_pal  = mode.pal;

endmodule

// File: rtl/vid_slot_timing_chk.sv
module vid_slot_timing_chk #(
   parameter int SLOT_W     = 8,
   parameter int LINE_W     = 9,
   parameter int FRAME_W    = 16,
   parameter int NTSC_LINES = 262,
   parameter int PAL_LINES  = 313
) (
   input logic               clk,
   input logic               rst,
   input logic [SLOT_W-1:0]  hslot,
   input logic [LINE_W-1:0]  vline,
   input logic [FRAME_W-1:0] frame_cnt,
   input logic               line_chg,
   input logic               mode_wide,
   input logic               mode_pal
);

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
      !$stable(hslot) |-> (hslot == SLOT_W'($past(hslot) + 1'b1))); // R2

   AST_LC_SINGLE: assert property (@(posedge clk) disable iff (rst)
      line_chg |=> !line_chg); // R8

   AST_LINE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      !$stable(vline) |-> $past(line_chg)); // R8

   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
      mode_pal ? (32'(vline) < PAL_LINES) : (32'(vline) < NTSC_LINES)); // R9

   AST_MODE_AT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
      !$stable({mode_wide, mode_pal}) |-> ($past(hslot) == '0 && $past(vline) == '0)); // R10

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
      !$stable(frame_cnt) |-> (frame_cnt == FRAME_W'($past(frame_cnt) + 1'b1) && $past(line_chg))); // R11

endmodule

bind vid_slot_timing vid_slot_timing_chk #(
   .SLOT_W    (SLOT_W),
   .LINE_W    (LINE_W),
   .FRAME_W   (FRAME_W),
   .NTSC_LINES(NTSC_LINES),
   .PAL_LINES (PAL_LINES)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .hslot    (hslot),
   .vline    (vline),
   .frame_cnt(frame_cnt),
   .line_chg (line_chg),
   .mode_wide(mode_wide),
   .mode_pal (mode_pal)
);

// File: tb/vid_slot_timing_tb_top.sv
`timescale 1ns/1ps
module vid_slot_timing_tb_top;

   localparam int T_NTSC_LINES  = 10;
   localparam int T_NTSC_ACTIVE = 1;
   localparam int T_PAL_LINES   = 12;
   localparam int T_PAL_ACTIVE  = 2;
   localparam int RUN_CYCLES    = 140000;
   localparam int WATCHDOG      = 200000;

   logic        clk = 1'b0;
   logic        rst;
   logic        wide_in, pal_in;
   logic [7:0]  hslot;
   logic [8:0]  vline;
   logic [15:0] frame_cnt;
   logic        hsync, hblank, line_chg, vint_strobe, mode_wide, mode_pal;

   always #2 clk = ~clk;

   vid_slot_timing #(
      .NTSC_LINES (T_NTSC_LINES),
      .NTSC_ACTIVE(T_NTSC_ACTIVE),
      .PAL_LINES  (T_PAL_LINES),
      .PAL_ACTIVE (T_PAL_ACTIVE)
   ) dut_i (
      .clk(clk), .rst(rst), .wide_in(wide_in), .pal_in(pal_in),
      .hslot(hslot), .vline(vline), .frame_cnt(frame_cnt),
      .hsync(hsync), .hblank(hblank), .line_chg(line_chg),
      .vint_strobe(vint_strobe), .mode_wide(mode_wide), .mode_pal(mode_pal)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Reference state
   int m_phase, m_slot, m_line, m_frame;
   bit m_wide, m_pal;

   function automatic int slot_len(bit w, int s);
      int k;
      if (!w) return 20;
      if (s < 234 || s > 250) return 16;
      k = s - 234;
      if (k == 0 || k == 16) return 19;   // R3
      if (k % 4 == 0) return 18;
      return 20;
   endfunction

   function automatic int lines_of(bit p);   return p ? T_PAL_LINES : T_NTSC_LINES;   endfunction
   function automatic int inact_of(bit p);   return p ? T_PAL_ACTIVE : T_NTSC_ACTIVE; endfunction
   function automatic int lc_of(bit w);      return w ? 165 : 133; endfunction
   function automatic bit hs_exp(bit w, int s);
      return w ? (s >= 234 && s <= 250) : (s >= 210 && s <= 242);
   endfunction
   function automatic bit hb_exp(bit w, int s);
      return w ? (s >= 178) : (s >= 233);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic model_step();
      int nl;
      bit lc;
      bit latch;
      if (rst) begin
         m_phase = 0; m_slot = 0; m_line = 0; m_frame = 0; m_wide = 0; m_pal = 0;
         return;
      end
      latch = (m_phase == 0 && m_slot == 0 && m_line == 0);
      lc    = (m_phase == 0 && m_slot == lc_of(m_wide));
      if (lc) begin
         nl = (m_line == lines_of(m_pal) - 1) ? 0 : m_line + 1;
         if (nl == inact_of(m_pal) + 8) m_frame = (m_frame + 1) & 16'hFFFF;
         m_line = nl;
      end
      if (m_phase == slot_len(m_wide, m_slot) - 1) begin
         m_phase = 0;
         m_slot  = (m_slot + 1) % 256;
      end else begin
         m_phase++;
      end
      if (latch) begin
         m_wide = wide_in;
         m_pal  = pal_in;
      end
   endtask

   int  hs_run;
   bit  hs_valid;

   initial begin
      void'($urandom(32'd20250611));
      rst     = 1'b1;
      wide_in = 1'b1;
      pal_in  = 1'b0;
      m_phase = 0; m_slot = 0; m_line = 0; m_frame = 0; m_wide = 0; m_pal = 0;
      hs_run  = 0;
      hs_valid = 1'b0;
      for (int n = 0; n < RUN_CYCLES; n++) begin
         @(negedge clk);
         if (n == 3) begin
            // R1: state while reset is held
            check(hslot == 0 && vline == 0 && frame_cnt == 0 && !mode_wide && !mode_pal,
                  "R1 reset counters", int'(hslot) + int'(vline) + int'(frame_cnt), 0);
            check(!hsync && !hblank && !line_chg && !vint_strobe,
                  "R1 reset flags", int'({hsync, hblank, line_chg, vint_strobe}), 0);
         end
         check(int'(hslot) == m_slot, "R2 R3 hslot", int'(hslot), m_slot);
         check(hsync == hs_exp(m_wide, m_slot), "R4 R5 hsync", int'(hsync), int'(hs_exp(m_wide, m_slot)));
         check(hblank == hb_exp(m_wide, m_slot), "R6 hblank", int'(hblank), int'(hb_exp(m_wide, m_slot)));
         check(vint_strobe == (m_phase == 0 && m_slot == (m_wide ? 4 : 23) && m_line == inact_of(m_pal)),
               "R7 vint_strobe", int'(vint_strobe),
               int'(m_phase == 0 && m_slot == (m_wide ? 4 : 23) && m_line == inact_of(m_pal)));
         check(line_chg == (m_phase == 0 && m_slot == lc_of(m_wide)), "R8 line_chg",
               int'(line_chg), int'(m_phase == 0 && m_slot == lc_of(m_wide)));
         check(int'(vline) == m_line, "R8 R9 vline", int'(vline), m_line);
         check(mode_wide == m_wide && mode_pal == m_pal, "R10 sampled mode",
               int'({mode_wide, mode_pal}), int'({m_wide, m_pal}));
         check(int'(frame_cnt) == m_frame, "R11 frame_cnt", int'(frame_cnt), m_frame);

         // Directed span measurement of one full sync period (R3, R5)
         if (rst) begin
            hs_run = 0; hs_valid = 1'b0;
         end else if (hsync) begin
            if (hs_run == 0 && !hs_valid) hs_valid = 1'b1;
            hs_run++;
         end else if (hs_run != 0) begin
            if (hs_valid && n > 8)
               check(hs_run == (mode_wide ? 332 : 660), mode_wide ? "R3 wide sync clocks" : "R5 narrow sync clocks",
                     hs_run, mode_wide ? 332 : 660);
            hs_run = 0; hs_valid = 1'b0;
         end

         // Stimulus: reset for four cycles, then random mode requests (R10)
         rst = (n < 4);
         if (!rst && ($urandom % 2500) == 0) begin
            wide_in = 1'($urandom % 2);
            pal_in  = 1'($urandom % 2);
         end
         model_step();
         if (failures >= 20) break;
      end
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, RUN_CYCLES);
      finish_run();
   end

endmodule